// File: doc/BRIEF.md
# Paged SPI Register Port

This block is an SPI target that lets a host controller reach a bank of 16-bit registers split into pages. Page 0 holds read-only result words produced elsewhere on the chip. The remaining pages hold control words. The register storage itself sits outside the block. The block drives a simple read/write port toward that storage: a strobe, a page, an address and write data, with read data returned combinationally in the same cycle.

Each transaction opens with a 16-bit command word. The command word gives the direction, the page and the first address. Data words follow back to back while the select line stays low. After every data word the block advances the address. The address stops one past the last word of the page, and every read from there on returns all ones. The block also keeps one "fresh" flag per page-0 word. The result side sets a flag when it deposits a new value. The flag clears once the host has clocked that word out completely.

The serial pins are sampled with the system clock through a synchronizer, so SCLK must be several system clocks per half period. The result-load and register-file ports have no back-pressure: `res_load` is accepted in every cycle, and the register file must answer a read in the cycle it is strobed.

Top module: `spi_paged_regs`

## Requirements
- R1: SPI mode with SCLK idle low, data launched on the rising edge and captured on the falling edge (CPOL=0, CPHA=1), most significant bit first; `spi_miso` is 0 while `spi_ss_n` is high.
- R2: The first word after `spi_ss_n` falls is a command: bit 15 = 1 for read and 0 for write, bits 14:11 = page, bits 10:5 = start address, bits 4:0 ignored.
- R3: On a read, the data words return the contents of page/address, then page/address+1, and so on, each fetched with one `rf_rd_en` pulse.
- R4: Once the address passes PAGE_WORDS-1, the pointer stops advancing and every further read word is 0xFFFF.
- R5: On a write to page 1 through NUM_PAGES-1, each completed data word gives one `rf_wr_en` pulse carrying page, address and the word, and the address then advances. Words at or past PAGE_WORDS are dropped. `rf_rd_en` and `rf_wr_en` are never high together.
- R6: Writes addressed to page 0 never raise `rf_wr_en`; the page-0 contents read back unchanged.
- R7: For a page at or above NUM_PAGES, reads return 0xFFFF without any `rf_rd_en` toward that page, and writes are dropped.
- R8: Raising `spi_ss_n` discards a partly shifted word and clears the bit counter, so the next low period starts with a fresh command word.
- R9: `res_fresh[i]` is set in the cycle after `res_load[i]` is high. It clears when page-0 word i has been fully shifted out on a read. A set and a clear in the same cycle leave it set.
- R10: After reset, `spi_miso`, `rf_rd_en`, `rf_wr_en` and all `res_fresh` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_ss_n | input | 1 | Target select, active low |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_page | output | 4 | Page of the access |
| rf_addr | output | 6 | Word address within the page |
| rf_wdata | output | 16 | Write data |
| rf_rdata | input | 16 | Read data, valid in the strobe cycle |
| res_load | input | PAGE_WORDS | One bit per page-0 word: new result deposited |
| res_fresh | output | PAGE_WORDS | Per page-0 word: unread result present |

## Verification
The embedded assertions watch several rules in every cycle. They check that MISO is quiet and the bit counter is clear whenever select is high, and that no register-file write is ever aimed at page 0, at an absent page or past the page end. They also check that read and write strobes never overlap, that the pointer holds once saturated, and that a load always sets its fresh flag. The bench scenarios are needed for everything that depends on serial content: command decoding, MSB-first data order, address increment across a burst, the 0xFFFF fill, the recovery after an aborted word, and a fresh flag clearing only for the word actually read.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
  localparam int WORD_W   = 16;
  localparam int PAGE_W   = 4;
  localparam int ADDR_W   = 6;
  localparam int CMD_DIR  = 15;
  localparam int PAGE_LSB = 11;
  localparam int ADDR_LSB = 5;

  typedef enum logic [1:0] {PH_CMD, PH_RD, PH_WR} phase_t;

  typedef struct packed {
    logic              rd;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.rd   = w[CMD_DIR];
    c.page = w[PAGE_LSB +: PAGE_W];
    c.addr = w[ADDR_LSB +: ADDR_W];
    return c;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n,
  input  logic sclk,
  input  logic mosi,
  output logic ss_act,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s
);
  localparam logic [2:0] IDLE_PINS = 3'b100;  // {ss_n, sclk, mosi}

  logic [STAGES-1:0][2:0] stg;
  logic                   sclk_prev;
  logic                   sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg       <= {STAGES{IDLE_PINS}};
      sclk_prev <= 1'b0;
    end else begin
      stg[0] <= {ss_n, sclk, mosi};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_prev <= stg[STAGES-1][1];
    end
  end

  assign sclk_s    = stg[STAGES-1][1];
  assign ss_act    = !stg[STAGES-1][2];
  assign mosi_s    = stg[STAGES-1][0];
  assign sclk_rise = ss_act && sclk_s && !sclk_prev;
  assign sclk_fall = ss_act && !sclk_s && sclk_prev;
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_pg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_done,
  output logic              miso
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_word   <= '0;
      word_done <= 1'b0;
      miso      <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (!ss_act) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
        miso    <= 1'b0;
      end else begin
        if (tx_load) begin
          tx_sh <= tx_word;
        end else if (sclk_rise) begin
          miso  <= tx_sh[WORD_W-1];
          tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
        if (sclk_fall) begin
          rx_sh <= {rx_sh[WORD_W-2:0], mosi_s};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            rx_word   <= {rx_sh[WORD_W-2:0], mosi_s};
            word_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R1: output stays quiet while deselected
  p_miso_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> !miso);

  // R8: deselect always leaves the bit counter at zero
  p_bitcnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (bit_cnt == '0) && !word_done);
endmodule

// File: rtl/spi_pg_ctrl.sv
module spi_pg_ctrl
  import spi_pg_pkg::*;
#(
  parameter int NUM_PAGES  = 3,
  parameter int PAGE_WORDS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ss_act,
  input  logic                  word_done,
  input  logic [WORD_W-1:0]     rx_word,
  output logic                  tx_load,
  output logic [WORD_W-1:0]     tx_word,
  output logic                  rf_rd_en,
  output logic                  rf_wr_en,
  output logic [PAGE_W-1:0]     rf_page,
  output logic [ADDR_W-1:0]     rf_addr,
  output logic [WORD_W-1:0]     rf_wdata,
  input  logic [WORD_W-1:0]     rf_rdata,
  input  logic [PAGE_WORDS-1:0] res_load,
  output logic [PAGE_WORDS-1:0] res_fresh
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0]  PTR_END = PTR_W'(PAGE_WORDS);
  localparam logic [PAGE_W-1:0] PG_END  = PAGE_W'(NUM_PAGES);

  phase_t            phase_q;
  logic [PAGE_W-1:0] page_q;
  logic [PTR_W-1:0]  ptr_q;
  cmd_t              cmd;
  logic              is_cmd, fetch, f_ok, wr_go, rd_clr;
  logic [PAGE_W-1:0] f_page;
  logic [PTR_W-1:0]  f_ptr, ptr_inc;
  logic [PAGE_WORDS-1:0] clr_mask;

  assign cmd     = decode_cmd(rx_word);
  assign is_cmd  = (phase_q == PH_CMD);
  assign ptr_inc = (ptr_q >= PTR_END) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    fetch  = word_done && (is_cmd ? cmd.rd : (phase_q == PH_RD));
    f_page = is_cmd ? cmd.page : page_q;
    f_ptr  = is_cmd ? {1'b0, cmd.addr} : ptr_inc;
    f_ok   = (f_page < PG_END) && (f_ptr < PTR_END);
    wr_go  = word_done && (phase_q == PH_WR) && (page_q != '0) &&
             (page_q < PG_END) && (ptr_q < PTR_END);
    rd_clr = word_done && (phase_q == PH_RD) && (page_q == '0) &&
             (ptr_q < PTR_END);
  end

  assign rf_rd_en = fetch && f_ok;
  assign rf_wr_en = wr_go;
  assign rf_page  = wr_go ? page_q : f_page;
  assign rf_addr  = wr_go ? ptr_q[ADDR_W-1:0] : f_ptr[ADDR_W-1:0];
  assign rf_wdata = rx_word;

  generate
    for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_clr
      assign clr_mask[i] = rd_clr && (ptr_q == PTR_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_CMD;
      page_q    <= '0;
      ptr_q     <= '0;
      tx_load   <= 1'b0;
      tx_word   <= '0;
      res_fresh <= '0;
    end else begin
      tx_load   <= fetch;
      if (fetch) tx_word <= f_ok ? rf_rdata : '1;
      res_fresh <= (res_fresh & ~clr_mask) | res_load;
      if (!ss_act) begin
        phase_q <= PH_CMD;
      end else if (word_done) begin
        if (is_cmd) begin
          phase_q <= cmd.rd ? PH_RD : PH_WR;
          page_q  <= cmd.page;
          ptr_q   <= {1'b0, cmd.addr};
        end else begin
          ptr_q <= ptr_inc;
        end
      end
    end
  end

  // R6: writes only ever reach writable pages, inside the page
  p_wr_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_page != '0) && (rf_page < PG_END) && (rf_addr < ADDR_W'(PAGE_WORDS)));

  // R7: no fetch toward an absent page
  p_rd_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> (rf_page < PG_END));

  // R5: read and write strobes never coincide
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd_en && rf_wr_en));

  // R4: once past the end, the pointer holds
  p_ptr_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_act && word_done && !is_cmd && (ptr_q >= PTR_END)) |=> (ptr_q == $past(ptr_q)));

  // R9: a load always leaves its flag set
  p_fresh_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|res_load) |=> ((res_fresh & $past(res_load)) == $past(res_load)));
endmodule

// File: rtl/spi_paged_regs.sv
module spi_paged_regs
  import spi_pg_pkg::*;
#(
  parameter int NUM_PAGES   = 3,
  parameter int PAGE_WORDS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_ss_n,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  rf_rd_en,
  output logic                  rf_wr_en,
  output logic [3:0]            rf_page,
  output logic [5:0]            rf_addr,
  output logic [15:0]           rf_wdata,
  input  logic [15:0]           rf_rdata,
  input  logic [PAGE_WORDS-1:0] res_load,
  output logic [PAGE_WORDS-1:0] res_fresh
);
  logic              ss_act, sclk_rise, sclk_fall, mosi_s;
  logic              word_done, tx_load;
  logic [WORD_W-1:0] rx_word, tx_word;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ss_n(spi_ss_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .ss_act(ss_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
  );

  spi_word_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .tx_load(tx_load), .tx_word(tx_word),
    .rx_word(rx_word), .word_done(word_done), .miso(spi_miso)
  );

  spi_pg_ctrl #(.NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .word_done(word_done),
    .rx_word(rx_word), .tx_load(tx_load), .tx_word(tx_word),
    .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .rf_page(rf_page),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .res_load(res_load), .res_fresh(res_fresh)
  );
endmodule

// File: tb/spi_paged_regs_bench.sv
`timescale 1ns/1ps
module spi_paged_regs_bench;
  localparam int PW = 32;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, rf_rd_en, rf_wr_en;
  logic [3:0]  rf_page;
  logic [5:0]  rf_addr;
  logic [15:0] rf_wdata, rf_rdata;
  logic [PW-1:0] res_load = '0;
  logic [PW-1:0] res_fresh;

  int checks = 0, errors = 0, bad_rd = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_paged_regs u_spi_paged_regs (
    .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .rf_page(rf_page),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .res_load(res_load), .res_fresh(res_fresh)
  );

  function automatic logic [15:0] pat(input int p, input int a);
    return {4'(p), 4'hA, 2'b00, 6'(a)};
  endfunction

  function automatic logic [15:0] mk_cmd(input bit rd, input int p, input int a);
    return {rd, 4'(p), 6'(a), 5'b0};
  endfunction

  // register-file model
  logic [15:0] mem [3][PW];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++)
        for (int a = 0; a < PW; a++) mem[p][a] <= pat(p, a);
    end else if (rf_wr_en && rf_page < 4'd3 && rf_addr < 6'd32) begin
      mem[rf_page[1:0]][rf_addr[4:0]] <= rf_wdata;
    end
  end
  assign rf_rdata = (rf_page < 4'd3 && rf_addr < 6'd32) ? mem[rf_page[1:0]][rf_addr[4:0]] : 16'hDEAD;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] got_q[$];
  logic [25:0] wexp_q[$];
  string       wtag_q[$];

  always @(negedge clk) begin
    if (got_q.size() != 0 && exp_q.size() != 0) begin
      logic [15:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(g == e, t, {16'h0, g}, {16'h0, e});
    end
  end

  always @(negedge clk) begin
    if (rst_n && rf_wr_en) begin
      if (wexp_q.size() == 0) begin
        chk(1'b0, "R6 R7 unexpected write", {6'h0, rf_page, rf_addr, rf_wdata}, 32'h0);
      end else begin
        logic [25:0] w;
        string t;
        w = wexp_q.pop_front();
        t = wtag_q.pop_front();
        chk({rf_page, rf_addr, rf_wdata} == w, t, {6'h0, rf_page, rf_addr, rf_wdata}, {6'h0, w});
      end
    end
    if (rst_n && rf_rd_en && rf_page >= 4'd3) bad_rd++;
  end

  task automatic spi_word(input logic [15:0] tx, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      sclk = 1'b1; mosi = tx[i];
      repeat (HP) @(negedge clk);
      sclk = 1'b0; rx[i] = miso;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic sel();
    ss_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HP) @(negedge clk);
    ss_n = 1'b1; mosi = 1'b0;
    repeat (2*HP) @(negedge clk);
  endtask

  task automatic send_cmd(input bit rd, input int p, input int a);
    logic [15:0] r;
    spi_word(mk_cmd(rd, p, a), r);
  endtask

  task automatic rd_word(input logic [15:0] exp, input string tag);
    logic [15:0] r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    spi_word(16'h0000, r);
    got_q.push_back(r);
  endtask

  task automatic wr_word(input logic [15:0] d, input bit expect_wr, input int p, input int a, input string tag);
    logic [15:0] r;
    if (expect_wr) begin
      wexp_q.push_back({4'(p), 6'(a), d});
      wtag_q.push_back(tag);
    end
    spi_word(d, r);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(miso == 1'b0, "R10 miso after reset", {31'h0, miso}, 32'h0);
    chk(!rf_rd_en && !rf_wr_en, "R10 strobes after reset", {30'h0, rf_rd_en, rf_wr_en}, 32'h0);
    chk(res_fresh == '0, "R10 fresh flags after reset", res_fresh, 32'h0);

    // R2 R3 R1: read page 0 from address 0, MSB first
    sel(); send_cmd(1'b1, 0, 0);
    rd_word(pat(0, 0), "R2 R1 page0 word0");
    rd_word(pat(0, 1), "R3 page0 word1");
    rd_word(pat(0, 2), "R3 page0 word2");
    desel();
    chk(miso == 1'b0, "R1 miso idle after deselect", {31'h0, miso}, 32'h0);

    // R4: burst across the end of page 1
    sel(); send_cmd(1'b1, 1, 30);
    rd_word(pat(1, 30), "R4 page1 word30");
    rd_word(pat(1, 31), "R4 page1 word31");
    rd_word(16'hFFFF, "R4 past end fill 1");
    rd_word(16'hFFFF, "R4 past end fill 2");
    desel();

    // R5: write page 1, then read back
    sel(); send_cmd(1'b0, 1, 5);
    wr_word(16'h1234, 1'b1, 1, 5, "R5 write page1 a5");
    wr_word(16'hBEEF, 1'b1, 1, 6, "R5 write page1 a6");
    desel();
    sel(); send_cmd(1'b1, 1, 5);
    rd_word(16'h1234, "R5 readback a5");
    rd_word(16'hBEEF, "R5 readback a6");
    desel();

    // R5: write running past the end of page 2
    sel(); send_cmd(1'b0, 2, 31);
    wr_word(16'h5A5A, 1'b1, 2, 31, "R5 write page2 a31");
    wr_word(16'hC3C3, 1'b0, 2, 32, "R5 dropped past end");
    desel();
    sel(); send_cmd(1'b1, 2, 30);
    rd_word(pat(2, 30), "R5 page2 a30 untouched");
    rd_word(16'h5A5A, "R5 page2 a31 written");
    rd_word(16'hFFFF, "R4 page2 past end");
    desel();

    // R6: write to page 0 ignored
    sel(); send_cmd(1'b0, 0, 2);
    wr_word(16'h0BAD, 1'b0, 0, 2, "R6");
    desel();
    sel(); send_cmd(1'b1, 0, 2);
    rd_word(pat(0, 2), "R6 page0 unchanged");
    desel();

    // R7: absent page
    sel(); send_cmd(1'b1, 3, 0);
    rd_word(16'hFFFF, "R7 absent page read 1");
    rd_word(16'hFFFF, "R7 absent page read 2");
    desel();
    sel(); send_cmd(1'b0, 5, 0);
    wr_word(16'h1111, 1'b0, 5, 0, "R7");
    desel();

    // R8: abort a partial word, then a clean read
    sel();
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b1; mosi = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    desel();
    sel(); send_cmd(1'b1, 2, 4);
    rd_word(pat(2, 4), "R8 read after abort");
    desel();

    // R9: fresh flags
    res_load = (PW'(1) << 3) | (PW'(1) << 4);
    @(negedge clk);
    res_load = '0;
    chk(res_fresh[3] && res_fresh[4], "R9 flags set by load", {30'h0, res_fresh[4], res_fresh[3]}, 32'h3);
    sel(); send_cmd(1'b1, 0, 3);
    rd_word(pat(0, 3), "R9 read page0 a3");
    desel();
    chk(!res_fresh[3], "R9 flag 3 cleared by read", {31'h0, res_fresh[3]}, 32'h0);
    chk(res_fresh[4], "R9 flag 4 kept", {31'h0, res_fresh[4]}, 32'h1);

    repeat (4) @(negedge clk);
    chk(bad_rd == 0, "R7 fetch toward absent page", bad_rd, 32'h0);
    chk(wexp_q.size() == 0, "R5 missing writes", wexp_q.size(), 32'h0);
    chk(exp_q.size() == 0, "R3 unmatched reads", exp_q.size(), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule